// File: doc/BRIEF.md
# Burst-Capable Bus Master Sequencer

This block is the master side of a synchronous external bus. It accepts one read or write request at a time from internal logic and turns it into a bus tenure. A tenure always runs in the same order: arbitration, a one-cycle address phase that carries the transfer attributes, a data phase paced by slave acknowledges, and a one-cycle termination that reports success or abort. Every input is sampled, and every registered output changes, on the rising clock edge.

A transfer is either a single beat of up to four bytes or a 16-byte burst. The number of burst beats follows the width of the addressed port: four beats on a 32-bit port, eight on a 16-bit port and sixteen on an 8-bit port. The address and the attributes stay fixed for the whole tenure. The requester reads the current beat index and supplies the matching write data. The sequencer works with either arbiter mode. In internal mode it only waits until no other master holds the bus. In external mode it raises a bus request and starts only on a grant that arrives while the bus is free.

Top module: `bus_master_seq`

## Requirements
- R1: While the active-low synchronous reset is low, and in the cycle after it is released, `bus_busy_out`, `bus_start`, `bus_doe`, `bus_req`, `done`, `abort` and `rd_valid` are 0 and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. It then passes through arbitration. `bus_start` is high for exactly one cycle, and it rises in the cycle right after the first edge on which the arbitration condition holds.
- R3: With `ext_arb`=0 at acceptance, `bus_req` stays low. The tenure starts only after an edge on which `bus_busy_in` is sampled low, whatever `bus_grant` is.
- R4: With `ext_arb`=1 at acceptance, `bus_req` is high during arbitration and `bus_busy_out` stays low. The tenure starts only after an edge on which `bus_grant` is 1 and `bus_busy_in` is 0.
- R5: `bus_busy_out` is high from the `bus_start` cycle through the last data-phase cycle. It is low in the termination cycle.
- R6: A single transfer (`req_burst`=0) has exactly one beat. A burst has 4 beats for `port_size`=0 (32-bit), 8 for `port_size`=1 (16-bit), 16 for `port_size`=2 (8-bit), and 4 for code 3.
- R7: `bus_beat` is 0 in the first data cycle. It increments by one after each data cycle in which `bus_ta` is sampled 1 and `bus_tea` is 0. `bus_ta` during the `bus_start` cycle has no effect.
- R8: On a write, `bus_doe` is high in every data-phase cycle and in no other cycle, never in the `bus_start` cycle. `bus_dout` equals `wr_data` while `bus_doe` is 1 and is 0 otherwise. On a read, `bus_doe` stays low.
- R9: On a read, each acknowledged beat gives `rd_valid`=1 in the next cycle, with `rd_data` equal to `bus_din` sampled at that acknowledge. `rd_valid` is 0 in all other cycles.
- R10: `bus_tea` sampled high in a data cycle ends the tenure. The next cycle is the termination with `abort`=1. `bus_tea` overrides a simultaneous `bus_ta`: no beat is counted and `rd_valid` stays 0.
- R11: Termination lasts one cycle, with `done`=1, `bus_busy_out`=0 and `bus_doe`=0. In the cycle after it, `req_ready`=1 and `done`=0.
- R12: `bus_addr`, `bus_rw` (1 = write) and `bus_burst` equal the accepted request from `bus_start` through the end of the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Sequencer idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = 16-byte burst, 0 = single beat |
| req_addr | input | AW | Transfer address |
| port_size | input | 2 | 0 = 32-bit, 1 = 16-bit, 2 = 8-bit port |
| ext_arb | input | 1 | 1 = external arbiter mode |
| wr_data | input | DW | Write data for the beat shown on bus_beat |
| rd_valid | output | 1 | Read beat captured |
| rd_data | output | DW | Captured read data |
| done | output | 1 | Termination cycle |
| abort | output | 1 | Termination was an abort |
| bus_req | output | 1 | Bus request to external arbiter |
| bus_grant | input | 1 | Grant from external arbiter |
| bus_busy_in | input | 1 | Another master holds the bus |
| bus_busy_out | output | 1 | This master owns the bus |
| bus_start | output | 1 | Address phase strobe |
| bus_addr | output | AW | Bus address |
| bus_rw | output | 1 | Bus direction, 1 = write |
| bus_burst | output | 1 | Burst attribute |
| bus_beat | output | CW | Current beat index |
| bus_ta | input | 1 | Transfer acknowledge |
| bus_tea | input | 1 | Transfer error |
| bus_din | input | DW | Read data from slave |
| bus_dout | output | DW | Write data to bus |
| bus_doe | output | 1 | Data drive enable |

## Verification
A wrong state register shows up at the ports in the very next cycle. The strobe, busy and drive-enable outputs are decoded straight from the state, so a lost or extra state appears as a misplaced `bus_start`, a `bus_busy_out` gap or a `done` at the wrong time. A miscounted beat shows up at the next acknowledge as a `bus_beat` mismatch, and at the end of the burst as a termination that comes one beat early or late. A corrupted latched attribute is visible on `bus_addr`, `bus_rw` or `bus_burst` from the address cycle onward. Mixing arbitration modes, contention, stalls and errors at every beat position exposes these faults within a few cycles of where they occur.

// File: rtl/bms_pkg.sv
package bms_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ARB  = 3'd1,
        ST_ADDR = 3'd2,
        ST_DATA = 3'd3,
        ST_TERM = 3'd4
    } state_e;

    localparam logic [1:0] PSZ_32 = 2'd0;
    localparam logic [1:0] PSZ_16 = 2'd1;
    localparam logic [1:0] PSZ_8  = 2'd2;

    // Beats needed to move one request for the given port width.
    function automatic int unsigned beats_for(input logic burst,
                                              input logic [1:0] psz,
                                              input int unsigned burst_bytes);
        if (!burst) return 1;
        case (psz)
            PSZ_16:  return burst_bytes / 2;
            PSZ_8:   return burst_bytes;
            default: return burst_bytes / 4;
        endcase
    endfunction

endpackage

// File: rtl/bms_arb.sv
module bms_arb (
    input  logic active,
    input  logic ext,
    input  logic grant,
    input  logic busy_in,
    output logic win,
    output logic req
);
    always_comb begin
        req = active && ext;
        win = active && !busy_in && (!ext || grant);
    end
endmodule

// File: rtl/bms_beat.sv
module bms_beat #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [CW-1:0] last_idx,
    output logic [CW-1:0] cnt,
    output logic          at_last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (adv) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt     = cnt_q;
    assign at_last = (cnt_q == last_idx);
endmodule

// File: rtl/bus_master_seq.sv
module bus_master_seq #(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int BURST_BYTES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic                          req_burst,
    input  logic [AW-1:0]                 req_addr,
    input  logic [1:0]                    port_size,
    input  logic                          ext_arb,
    input  logic [DW-1:0]                 wr_data,
    output logic                          rd_valid,
    output logic [DW-1:0]                 rd_data,
    output logic                          done,
    output logic                          abort,
    output logic                          bus_req,
    input  logic                          bus_grant,
    input  logic                          bus_busy_in,
    output logic                          bus_busy_out,
    output logic                          bus_start,
    output logic [AW-1:0]                 bus_addr,
    output logic                          bus_rw,
    output logic                          bus_burst,
    output logic [$clog2(BURST_BYTES)-1:0] bus_beat,
    input  logic                          bus_ta,
    input  logic                          bus_tea,
    input  logic [DW-1:0]                 bus_din,
    output logic [DW-1:0]                 bus_dout,
    output logic                          bus_doe
);
    import bms_pkg::*;

    localparam int CW = $clog2(BURST_BYTES);

    typedef struct packed {
        state_e          st;
        logic [AW-1:0]   addr;
        logic            wr;
        logic            burst;
        logic            ext;
        logic [CW-1:0]   last;
        logic            err;
        logic            rdv;
        logic [DW-1:0]   rdd;
    } regs_t;

    regs_t r_d, r_q;

    logic          win, arb_req;
    logic          beat_clr, beat_adv, at_last;
    logic [CW-1:0] beat_cnt;
    logic          in_data;
    logic          ext_mode;

    assign in_data  = (r_q.st == ST_DATA);
    assign ext_mode = r_q.ext;

    bms_arb u_arb (
        .active  (r_q.st == ST_ARB),
        .ext     (r_q.ext),
        .grant   (bus_grant),
        .busy_in (bus_busy_in),
        .win     (win),
        .req     (arb_req)
    );

    assign beat_clr = (r_q.st == ST_ADDR);
    assign beat_adv = in_data && bus_ta && !bus_tea;

    bms_beat #(.CW(CW)) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (beat_clr),
        .adv      (beat_adv),
        .last_idx (r_q.last),
        .cnt      (beat_cnt),
        .at_last  (at_last)
    );

    always_comb begin
        r_d     = r_q;
        r_d.rdv = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_ARB;
                    r_d.addr  = req_addr;
                    r_d.wr    = req_write;
                    r_d.burst = req_burst;
                    r_d.ext   = ext_arb;
                    r_d.last  = CW'(beats_for(req_burst, port_size, BURST_BYTES) - 1);
                    r_d.err   = 1'b0;
                end
            end
            ST_ARB: begin
                if (win) r_d.st = ST_ADDR;
            end
            ST_ADDR: begin
                r_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (bus_tea) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_TERM;
                end else if (bus_ta) begin
                    r_d.rdv = !r_q.wr;
                    r_d.rdd = bus_din;
                    if (at_last) r_d.st = ST_TERM;
                end
            end
            ST_TERM: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_ready    = (r_q.st == ST_IDLE);
    assign bus_req      = arb_req;
    assign bus_start    = (r_q.st == ST_ADDR);
    assign bus_busy_out = (r_q.st == ST_ADDR) || in_data;
    assign bus_doe      = in_data && r_q.wr;
    assign bus_dout     = bus_doe ? wr_data : '0;
    assign bus_addr     = r_q.addr;
    assign bus_rw       = r_q.wr;
    assign bus_burst    = r_q.burst;
    assign bus_beat     = beat_cnt;
    assign done         = (r_q.st == ST_TERM);
    assign abort        = (r_q.st == ST_TERM) && r_q.err;
    assign rd_valid     = r_q.rdv;
    assign rd_data      = r_q.rdd;
endmodule

// File: rtl/bms_checker.sv
module bms_checker #(
    parameter int AW = 32,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ext_mode,
    input logic          req_ready,
    input logic          bus_req,
    input logic          bus_grant,
    input logic          bus_busy_in,
    input logic          bus_busy_out,
    input logic          bus_start,
    input logic [AW-1:0] bus_addr,
    input logic [CW-1:0] bus_beat,
    input logic          bus_ta,
    input logic          bus_tea,
    input logic          bus_doe,
    input logic          done,
    input logic          abort,
    input logic          rd_valid
);
    logic data_cyc;
    assign data_cyc = bus_busy_out && !bus_start;

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !bus_start); // R2
    AST_START_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> !$past(bus_busy_in)); // R3
    AST_REQ_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ext_mode); // R3
    AST_EXT_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && ext_mode) |-> $past(bus_grant)); // R4
    AST_BUSY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> bus_busy_out); // R5
    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (bus_beat == '0)); // R7
    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_cyc && $past(bus_busy_out) && !$past(bus_start))
        |-> (bus_beat == $past(bus_beat) || bus_beat == $past(bus_beat) + 1'b1)); // R7
    AST_DOE_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> data_cyc); // R8
    AST_TEA_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_cyc && bus_tea) |=> (done && abort && !rd_valid)); // R10
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_busy_out && !bus_doe)); // R11
    AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !done)); // R11
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_cyc |-> $stable(bus_addr)); // R12
endmodule

bind bus_master_seq bms_checker #(.AW(AW), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_mode     (ext_mode),
    .req_ready    (req_ready),
    .bus_req      (bus_req),
    .bus_grant    (bus_grant),
    .bus_busy_in  (bus_busy_in),
    .bus_busy_out (bus_busy_out),
    .bus_start    (bus_start),
    .bus_addr     (bus_addr),
    .bus_beat     (bus_beat),
    .bus_ta       (bus_ta),
    .bus_tea      (bus_tea),
    .bus_doe      (bus_doe),
    .done         (done),
    .abort        (abort),
    .rd_valid     (rd_valid)
);

// File: tb/bus_master_seq_test.sv
`timescale 1ns/1ps
module bus_master_seq_test;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int BB = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0, ext_arb = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    port_size = '0;
    logic [DW-1:0] wr_data = '0, bus_din = '0;
    logic          bus_grant = 1'b0, bus_busy_in = 1'b0, bus_ta = 1'b0, bus_tea = 1'b0;
    logic          req_ready, rd_valid, done, abort, bus_req, bus_busy_out, bus_start;
    logic          bus_rw, bus_burst, bus_doe;
    logic [DW-1:0] rd_data, bus_dout;
    logic [AW-1:0] bus_addr;
    logic [CW-1:0] bus_beat;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    bus_master_seq #(.AW(AW), .DW(DW), .BURST_BYTES(BB)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
        .port_size(port_size), .ext_arb(ext_arb), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .abort(abort),
        .bus_req(bus_req), .bus_grant(bus_grant), .bus_busy_in(bus_busy_in),
        .bus_busy_out(bus_busy_out), .bus_start(bus_start), .bus_addr(bus_addr),
        .bus_rw(bus_rw), .bus_burst(bus_burst), .bus_beat(bus_beat),
        .bus_ta(bus_ta), .bus_tea(bus_tea), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_doe(bus_doe)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    function automatic int exp_beats(input bit bst, input logic [1:0] psz);
        if (!bst) return 1;
        case (psz)
            2'd1:    return 8;
            2'd2:    return 16;
            default: return 4;
        endcase
    endfunction

    function automatic logic [31:0] rpat(input logic [31:0] a, input int b);
        return (a * 32'd7) + (b * 32'h01010101) + 32'h5a;
    endfunction

    function automatic logic [31:0] wpat(input logic [31:0] a, input int b);
        return ~a ^ (b * 32'h00110011) ^ 32'hc3c3_0000;
    endfunction

    task automatic run_tenure(input bit wr, input bit bst, input logic [1:0] psz,
                              input bit ext, input logic [31:0] addr,
                              input int busy_cyc, input int grant_dly,
                              input int tea_beat, input bit tea_ta);
        int nb, beat, cyc, arb_cyc;
        bit acc, ts_seen, prev_win, nxt_rd, exp_rd, nxt_term, term, nxt_abort, ab_exp, fin;
        logic [31:0] nxt_val, rd_exp;
        nb = exp_beats(bst, psz);
        beat = 0; cyc = 0; arb_cyc = 0;
        acc = 0; ts_seen = 0; prev_win = 0; nxt_rd = 0; nxt_term = 0; nxt_abort = 0; fin = 0;
        nxt_val = '0;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_burst = bst; req_addr = addr;
        port_size = psz; ext_arb = ext;
        bus_busy_in = (busy_cyc > 0); bus_grant = 0; bus_ta = 0; bus_tea = 0;
        while (!fin) begin
            @(negedge clk);
            cyc++;
            exp_rd = nxt_rd; rd_exp = nxt_val; term = nxt_term; ab_exp = nxt_abort;
            nxt_rd = 0; nxt_term = 0;
            bus_ta = 0; bus_tea = 0;
            if (cyc > 400) begin
                chk(0, "WATCHDOG tenure", cyc, 0);
                break;
            end
            if (ts_seen) begin
                chk(rd_valid == exp_rd, "R9 rd_valid", rd_valid, exp_rd);
                if (exp_rd) chk(rd_data == rd_exp, "R9 rd_data", rd_data, rd_exp);
            end
            if (!acc && !req_ready) begin
                acc = 1; req_valid = 0;
            end
            if (term) begin
                chk(done == 1'b1, ab_exp ? "R10 done" : "R6 done after beats", done, 1);
                chk(abort == ab_exp, "R10 abort", abort, ab_exp);
                chk(!bus_busy_out && !bus_doe, "R11 quiet", {bus_busy_out, bus_doe}, 0);
                chk(!bus_busy_out, "R5 busy off", bus_busy_out, 0);
                fin = 1;
            end else if (acc && !ts_seen) begin
                if (bus_start) begin
                    chk(prev_win, ext ? "R4 start cond" : "R3 start cond", 1, prev_win);
                    chk(bus_addr == addr, "R12 addr", bus_addr, addr);
                    chk(bus_rw == wr && bus_burst == bst, "R12 attrs", {bus_rw, bus_burst}, {wr, bst});
                    chk(bus_busy_out, "R5 busy at start", bus_busy_out, 1);
                    chk(!bus_doe && bus_dout == '0, "R8 no drive at start", bus_doe, 0);
                    ts_seen = 1;
                    bus_busy_in = 0; bus_grant = 0;
                    bus_ta = 1'($urandom_range(0, 1));
                end else begin
                    chk(!prev_win, "R2 start late", 0, 1);
                    chk(bus_req == ext, ext ? "R4 bus_req" : "R3 bus_req", bus_req, ext);
                    chk(!bus_busy_out, "R4 busy before start", bus_busy_out, 0);
                    arb_cyc++;
                    bus_busy_in = (arb_cyc <= busy_cyc);
                    bus_grant = ext ? (arb_cyc > grant_dly) : 1'($urandom_range(0, 1));
                    prev_win = !bus_busy_in && (!ext || bus_grant);
                end
            end else if (ts_seen) begin
                chk(!done, "R6 early end", done, 0);
                chk(bus_beat == beat, "R7 beat", bus_beat, beat);
                chk(bus_busy_out, "R5 busy in data", bus_busy_out, 1);
                chk(bus_doe == wr, "R8 doe", bus_doe, wr);
                chk(bus_addr == addr && bus_rw == wr, "R12 hold", bus_addr, addr);
                if (beat == tea_beat) begin
                    bus_tea = 1; bus_ta = tea_ta;
                    nxt_term = 1; nxt_abort = 1;
                end else if ($urandom_range(0, 9) < 7) begin
                    bus_ta = 1;
                    if (!wr) begin
                        bus_din = rpat(addr, beat);
                        nxt_rd = 1; nxt_val = bus_din;
                    end
                    beat++;
                    if (beat == nb) begin
                        nxt_term = 1; nxt_abort = 0;
                    end
                end else begin
                    bus_din = $urandom;
                end
                if (wr) begin
                    wr_data = wpat(addr, int'(bus_beat));
                    #1;
                    chk(bus_dout == wr_data, "R8 dout", bus_dout, wr_data);
                end
            end
        end
        @(negedge clk);
        chk(req_ready && !done, "R11 back to idle", {req_ready, done}, 2);
        bus_busy_in = 0; bus_grant = 0; bus_ta = 0; bus_tea = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "WATCHDOG global", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk(!bus_busy_out && !bus_start && !bus_doe && !bus_req && !done && !abort && !rd_valid && req_ready,
            "R1 in reset", {bus_busy_out, bus_start, bus_doe, bus_req, done, req_ready}, 1);
        rst_n = 1;
        @(negedge clk);
        chk(!bus_busy_out && !bus_start && !bus_doe && !bus_req && !done && !abort && !rd_valid && req_ready,
            "R1 after reset", {bus_busy_out, bus_start, bus_doe, bus_req, done, req_ready}, 1);

        // Directed corners
        run_tenure(0, 1, 2'd0, 0, 32'h0000_1000, 0, 0, -1, 0); // R6 4-beat read
        run_tenure(1, 1, 2'd1, 0, 32'h0000_2000, 2, 0, -1, 0); // R6 8-beat write, R3 busy
        run_tenure(0, 1, 2'd2, 1, 32'h0000_3000, 1, 3, -1, 0); // R6 16-beat, R4 late grant
        run_tenure(1, 0, 2'd0, 1, 32'h0000_4004, 3, 0, -1, 0); // R4 grant while busy
        run_tenure(0, 1, 2'd3, 0, 32'h0000_5000, 0, 0, -1, 0); // R6 code 3
        run_tenure(0, 0, 2'd1, 0, 32'h0000_6002, 0, 0, -1, 0); // R6 single on 16-bit
        run_tenure(0, 1, 2'd0, 0, 32'h0000_7000, 0, 0, 0, 1);  // R10 tea with ta, beat 0
        run_tenure(1, 1, 2'd2, 1, 32'h0000_8000, 0, 0, 15, 0); // R10 tea at last beat
        run_tenure(0, 1, 2'd1, 1, 32'h0000_9000, 0, 0, 3, 1);  // R10 mid burst

        // Random mix
        for (int i = 0; i < 40; i++) begin
            bit wr, bst, ext;
            logic [1:0] psz;
            int nb, tb;
            wr  = 1'($urandom_range(0, 1));
            bst = 1'($urandom_range(0, 1));
            ext = 1'($urandom_range(0, 1));
            psz = 2'($urandom_range(0, 3));
            nb  = exp_beats(bst, psz);
            tb  = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, nb - 1)) : -1;
            run_tenure(wr, bst, psz, ext, $urandom, int'($urandom_range(0, 3)),
                       int'($urandom_range(0, 3)), tb, 1'($urandom_range(0, 1)));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule